// File: doc/BRIEF.md
# Immediate-Offset Byte Load Unit

This block carries out one load-byte instruction whose address is a base register plus or minus an unsigned immediate. It serves a 32-bit core with two instruction sets. One set uses fixed 32-bit words. The other mixes 16-bit and 32-bit encodings. The core presents the instruction word, the set select and the condition result, and the block reads the base register through a combinational read port. It works out the access address and issues one byte request on a request/response memory port.

When the response arrives, the block retires the instruction. In that cycle it writes the zero-extended byte to the destination register on one write port. When the encoding asks for it, it also writes the updated base on a second write port in the same cycle. Some encodings belong to neighbouring operations: the PC-relative literal form, the preload hint and the unprivileged form. The block does not execute these; it retires them with a hand-off flag. Undefined and unpredictable encodings retire with the undefined flag, and they issue no request and write no register.

Top module: `lbu_byte_load`

## Requirements
- R1: After reset, `instr_ready` is 1 and `mem_req`, `retire`, `dst_we` and `wb_we` are all 0.
- R2: Fixed set (`mixed_set`=0). The word must have cond[31:28]≠1111, [27:25]=010, [22]=1 and [20]=1. The fields are base [19:16], destination [15:12], offset [11:0], pre-index P=[24], add U=[23] and W=[21]. The offset address is base+offset when U=1 and base−offset when U=0, modulo 2^32. The request address is the offset address when P=1 and the unmodified base when P=0.
- R3: An executed instruction raises `mem_req` for exactly one cycle, in the cycle after it is accepted. It retires in the cycle after `mem_rsp_valid` is sampled high. In that cycle `dst_we`=1 and `dst_data` is the response byte with 24 zero bits above it.
- R4: Writeback happens when P=0 or W=1 in the fixed set, and when W=1 in the second mixed 32-bit form. It sets `wb_we`=1 in the retire cycle, with `wb_idx` equal to the base index and `wb_data` equal to the offset address. Otherwise `wb_we` stays 0.
- R5: 16-bit form (`mixed_set`=1, bits [31:16] zero). Bits [15:11] must be 01111. The fields are offset [10:6], base [5:3] and destination [2:0]. The offset is always added, the access is always pre-indexed and there is never a writeback.
- R6: First mixed 32-bit form (bits [31:20]=0xF89). The fields are base [19:16], destination [15:12] and offset [11:0]. The offset is added, the access is pre-indexed and there is no writeback. A destination of 1111 retires with `flag_preload`.
- R7: Second mixed 32-bit form (bits [31:20]=0xF81 and [11]=1). The fields are P=[10], U=[9], W=[8] and offset [7:0]. Destination 1111 with P,U,W=1,0,0 gives `flag_preload`. P,U,W=1,1,0 gives `flag_unpriv`. P=0 with W=0 gives `flag_undef`.
- R8: On any 32-bit form, a base field of 1111 retires with `flag_literal`. In the fixed set, P=0 with W=1 retires with `flag_unpriv`. Neither case issues a request.
- R9: The block retires with `flag_undef` and issues no request or register write when any of these holds: destination 15 in the fixed set, destination 15 with W=1 in the second mixed form, writeback with base equal to destination, or a word that matches no form.
- R10: When `cond_pass` is 0 at acceptance, the instruction retires in the next cycle with no request, no write and no flag.
- R11: Hand-off and undefined outcomes retire in the cycle after acceptance. At most one flag is ever high, and only together with `retire`.
- R12: While a request is outstanding, `instr_ready` is 0 and `instr_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction presented |
| instr_word | input | 32 | Instruction word (16-bit encodings in [15:0]) |
| mixed_set | input | 1 | 0 = fixed 32-bit set, 1 = mixed 16/32-bit set |
| cond_pass | input | 1 | Condition check passed |
| instr_ready | output | 1 | Block can accept an instruction |
| base_sel | output | 4 | Register file read index (base) |
| base_val | input | 32 | Register file read data |
| mem_req | output | 1 | Byte read request, one cycle |
| mem_addr | output | 32 | Byte address of the request |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_byte | input | 8 | Read response byte |
| retire | output | 1 | Instruction completes this cycle |
| dst_we | output | 1 | Destination write enable |
| dst_idx | output | 4 | Destination register index |
| dst_data | output | 32 | Zero-extended loaded byte |
| wb_we | output | 1 | Base writeback enable |
| wb_idx | output | 4 | Base register index |
| wb_data | output | 32 | Updated base value |
| flag_literal | output | 1 | Hand-off: PC-relative literal form |
| flag_preload | output | 1 | Hand-off: preload hint |
| flag_unpriv | output | 1 | Hand-off: unprivileged form |
| flag_undef | output | 1 | Undefined or unpredictable encoding |

## Verification
The assertions take four things for granted about the inputs. The register file answers `base_sel` in the same cycle. Memory gives one response per request and never sends one without a request outstanding. `instr_word` and `cond_pass` are only meaningful in cycles where `instr_valid` meets `instr_ready`. The bench keeps to these rules. Its memory model raises `mem_rsp_valid` only after it has seen a request, with a chosen delay, and lowers `instr_valid` before the retire cycle. While a request is outstanding, the bench deliberately keeps a stray instruction on the input, to show that the block ignores it.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned REG_IDX_W = 4;
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned OFF_W     = 12;

    typedef enum logic [2:0] {
        OP_EXEC, OP_LITERAL, OP_PRELOAD, OP_UNPRIV, OP_UNDEF
    } op_kind_e;

    typedef struct packed {
        op_kind_e               kind;
        logic [REG_IDX_W-1:0]   base_idx;
        logic [REG_IDX_W-1:0]   dest_idx;
        logic [OFF_W-1:0]       offset;
        logic                   pre_index;
        logic                   add_off;
        logic                   write_back;
    } dec_t;

    typedef enum logic { ST_IDLE, ST_WAIT } st_e;

    typedef struct packed {
        st_e                    st;
        logic                   retire;
        logic                   req;
        logic [XLEN-1:0]        addr;
        logic [REG_IDX_W-1:0]   dst;
        logic                   wb_pend;
        logic [REG_IDX_W-1:0]   wbi;
        logic [XLEN-1:0]        wbd;
        logic                   dwe;
        logic [XLEN-1:0]        ddata;
        logic                   wbwe;
        logic                   f_lit;
        logic                   f_pre;
        logic                   f_unp;
        logic                   f_und;
    } ctl_t;
endpackage

// File: rtl/lbu_decode.sv
module lbu_decode
    import lbu_pkg::*;
(
    input  logic [XLEN-1:0] word,
    input  logic            mixed_set,
    output dec_t            dec
);
    localparam logic [REG_IDX_W-1:0] PC_IDX = '1;

    logic [REG_IDX_W-1:0] w_base, w_dest;
    logic b_p, b_u, b_w, fx_p, fx_u, fx_w, fx_wb;

    assign w_base = word[19:16];
    assign w_dest = word[15:12];
    assign fx_p   = word[24];
    assign fx_u   = word[23];
    assign fx_w   = word[21];
    assign fx_wb  = !fx_p || fx_w;
    assign b_p    = word[10];
    assign b_u    = word[9];
    assign b_w    = word[8];

    always_comb begin
        dec          = '0;
        dec.kind     = OP_UNDEF;
        dec.base_idx = w_base;
        dec.dest_idx = w_dest;
        if (!mixed_set) begin
            dec.offset     = word[11:0];
            dec.pre_index  = fx_p;
            dec.add_off    = fx_u;
            dec.write_back = fx_wb;
            if (word[27:25] != 3'b010 || !word[22] || !word[20] || word[31:28] == 4'hF)
                dec.kind = OP_UNDEF;
            else if (w_base == PC_IDX)
                dec.kind = OP_LITERAL;
            else if (!fx_p && fx_w)
                dec.kind = OP_UNPRIV;
            else if (w_dest == PC_IDX || (fx_wb && w_base == w_dest))
                dec.kind = OP_UNDEF;
            else
                dec.kind = OP_EXEC;
        end else if (word[31:16] == 16'h0000) begin
            dec.base_idx  = {1'b0, word[5:3]};
            dec.dest_idx  = {1'b0, word[2:0]};
            dec.offset    = {{(OFF_W-5){1'b0}}, word[10:6]};
            dec.pre_index = 1'b1;
            dec.add_off   = 1'b1;
            dec.kind      = (word[15:11] == 5'b01111) ? OP_EXEC : OP_UNDEF;
        end else if (word[31:20] == 12'hF89) begin
            dec.offset    = word[11:0];
            dec.pre_index = 1'b1;
            dec.add_off   = 1'b1;
            if (w_dest == PC_IDX)      dec.kind = OP_PRELOAD;
            else if (w_base == PC_IDX) dec.kind = OP_LITERAL;
            else                       dec.kind = OP_EXEC;
        end else if (word[31:20] == 12'hF81 && word[11]) begin
            dec.offset     = {{(OFF_W-8){1'b0}}, word[7:0]};
            dec.pre_index  = b_p;
            dec.add_off    = b_u;
            dec.write_back = b_w;
            if (w_dest == PC_IDX && b_p && !b_u && !b_w)
                dec.kind = OP_PRELOAD;
            else if (w_base == PC_IDX)
                dec.kind = OP_LITERAL;
            else if (b_p && b_u && !b_w)
                dec.kind = OP_UNPRIV;
            else if (!b_p && !b_w)
                dec.kind = OP_UNDEF;
            else if ((w_dest == PC_IDX && b_w) || (b_w && w_base == w_dest))
                dec.kind = OP_UNDEF;
            else
                dec.kind = OP_EXEC;
        end
    end
endmodule

// File: rtl/lbu_agen.sv
module lbu_agen #(
    parameter int unsigned W     = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic [W-1:0]     base,
    input  logic [OFF_W-1:0] offset,
    input  logic             add_off,
    input  logic             pre_index,
    output logic [W-1:0]     access_addr,
    output logic [W-1:0]     update_addr
);
    logic [W-1:0] off_ext;
    assign off_ext     = {{(W-OFF_W){1'b0}}, offset};
    assign update_addr = add_off ? (base + off_ext) : (base - off_ext);
    assign access_addr = pre_index ? update_addr : base;
endmodule

// File: rtl/lbu_byte_load.sv
module lbu_byte_load
    import lbu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [XLEN-1:0]      instr_word,
    input  logic                 mixed_set,
    input  logic                 cond_pass,
    output logic                 instr_ready,
    output logic [REG_IDX_W-1:0] base_sel,
    input  logic [XLEN-1:0]      base_val,
    output logic                 mem_req,
    output logic [XLEN-1:0]      mem_addr,
    input  logic                 mem_rsp_valid,
    input  logic [BYTE_W-1:0]    mem_rsp_byte,
    output logic                 retire,
    output logic                 dst_we,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [XLEN-1:0]      dst_data,
    output logic                 wb_we,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [XLEN-1:0]      wb_data,
    output logic                 flag_literal,
    output logic                 flag_preload,
    output logic                 flag_unpriv,
    output logic                 flag_undef
);
    dec_t            dec;
    ctl_t            ctl_d, ctl_q;
    logic [XLEN-1:0] acc_addr, upd_addr;

    lbu_decode u_dec (
        .word      (instr_word),
        .mixed_set (mixed_set),
        .dec       (dec)
    );

    lbu_agen #(.W(XLEN), .OFF_W(OFF_W)) u_agen (
        .base        (base_val),
        .offset      (dec.offset),
        .add_off     (dec.add_off),
        .pre_index   (dec.pre_index),
        .access_addr (acc_addr),
        .update_addr (upd_addr)
    );

    assign base_sel = dec.base_idx;

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.retire = 1'b0;
        ctl_d.req    = 1'b0;
        ctl_d.dwe    = 1'b0;
        ctl_d.wbwe   = 1'b0;
        ctl_d.f_lit  = 1'b0;
        ctl_d.f_pre  = 1'b0;
        ctl_d.f_unp  = 1'b0;
        ctl_d.f_und  = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    if (!cond_pass) begin
                        ctl_d.retire = 1'b1;
                    end else begin
                        case (dec.kind)
                            OP_EXEC: begin
                                ctl_d.st      = ST_WAIT;
                                ctl_d.req     = 1'b1;
                                ctl_d.addr    = acc_addr;
                                ctl_d.dst     = dec.dest_idx;
                                ctl_d.wb_pend = dec.write_back;
                                ctl_d.wbi     = dec.base_idx;
                                ctl_d.wbd     = upd_addr;
                            end
                            OP_LITERAL: begin ctl_d.retire = 1'b1; ctl_d.f_lit = 1'b1; end
                            OP_PRELOAD: begin ctl_d.retire = 1'b1; ctl_d.f_pre = 1'b1; end
                            OP_UNPRIV:  begin ctl_d.retire = 1'b1; ctl_d.f_unp = 1'b1; end
                            default:    begin ctl_d.retire = 1'b1; ctl_d.f_und = 1'b1; end
                        endcase
                    end
                end
            end
            default: begin
                if (mem_rsp_valid) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.retire = 1'b1;
                    ctl_d.dwe    = 1'b1;
                    ctl_d.ddata  = {{(XLEN-BYTE_W){1'b0}}, mem_rsp_byte};
                    ctl_d.wbwe   = ctl_q.wb_pend;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign instr_ready  = (ctl_q.st == ST_IDLE);
    assign mem_req      = ctl_q.req;
    assign mem_addr     = ctl_q.addr;
    assign retire       = ctl_q.retire;
    assign dst_we       = ctl_q.dwe;
    assign dst_idx      = ctl_q.dst;
    assign dst_data     = ctl_q.ddata;
    assign wb_we        = ctl_q.wbwe;
    assign wb_idx       = ctl_q.wbi;
    assign wb_data      = ctl_q.wbd;
    assign flag_literal = ctl_q.f_lit;
    assign flag_preload = ctl_q.f_pre;
    assign flag_unpriv  = ctl_q.f_unp;
    assign flag_undef   = ctl_q.f_und;

    assert_flags_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flag_literal, flag_preload, flag_unpriv, flag_undef}));
    assert_flag_needs_retire_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_literal || flag_preload || flag_unpriv || flag_undef) |-> retire);
    assert_req_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $past(instr_valid && instr_ready && cond_pass));
    assert_write_on_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we || wb_we) |-> retire);
    assert_undef_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_undef |-> (!mem_req && !dst_we && !wb_we));
    assert_busy_not_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !instr_ready);
    assert_ports_distinct_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_we && wb_we) |-> (dst_idx != wb_idx));
    assert_single_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
endmodule

// File: tb/tb_lbu_byte_load.sv
module tb_lbu_byte_load;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        mixed_set = 1'b0;
    logic        cond_pass = 1'b1;
    logic        instr_ready;
    logic [3:0]  base_sel;
    logic [31:0] base_val;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_byte = '0;
    logic        retire, dst_we, wb_we;
    logic [3:0]  dst_idx, wb_idx;
    logic [31:0] dst_data, wb_data;
    logic        flag_literal, flag_preload, flag_unpriv, flag_undef;

    logic [31:0] rf [16];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    assign base_val = rf[base_sel];

    lbu_byte_load dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model: kind 0 exec, 1 literal, 2 preload, 3 unpriv, 4 undef
    function automatic void model(input logic [31:0] w, input bit mx, output int kind,
                                  output int bi, output int di, output int off,
                                  output bit pre, output bit add, output bit wbk);
        bit p, u, wf;
        kind = 4; bi = w[19:16]; di = w[15:12]; off = 0; pre = 0; add = 0; wbk = 0;
        if (!mx) begin
            p = w[24]; u = w[23]; wf = w[21];
            off = w[11:0]; pre = p; add = u; wbk = (!p) || wf;
            if (w[31:28] == 15 || w[27:25] != 2 || w[22] == 0 || w[20] == 0) kind = 4;
            else if (bi == 15) kind = 1;
            else if (!p && wf) kind = 3;
            else if (di == 15) kind = 4;
            else if (wbk && bi == di) kind = 4;
            else kind = 0;
        end else if (w[31:16] == 0) begin
            bi = w[5:3]; di = w[2:0]; off = w[10:6]; pre = 1; add = 1; wbk = 0;
            kind = (w[15:11] == 5'h0F) ? 0 : 4;
        end else if (w[31:20] == 12'hF89) begin
            off = w[11:0]; pre = 1; add = 1;
            if (di == 15) kind = 2; else if (bi == 15) kind = 1; else kind = 0;
        end else if (w[31:20] == 12'hF81 && w[11]) begin
            p = w[10]; u = w[9]; wf = w[8];
            off = w[7:0]; pre = p; add = u; wbk = wf;
            if (di == 15 && p && !u && !wf) kind = 2;
            else if (bi == 15) kind = 1;
            else if (p && u && !wf) kind = 3;
            else if (!p && !wf) kind = 4;
            else if (di == 15 && wf) kind = 4;
            else if (wf && bi == di) kind = 4;
            else kind = 0;
        end
    endfunction

    function automatic logic [31:0] enc_fx(int cond, int p, int u, int w, int b, int d, int o);
        return (32'(cond) << 28) | (32'h2 << 25) | (32'(p) << 24) | (32'(u) << 23) | (32'h1 << 22)
             | (32'(w) << 21) | (32'h1 << 20) | (32'(b) << 16) | (32'(d) << 12) | 32'(o & 12'hFFF);
    endfunction
    function automatic logic [31:0] enc_16(int o, int b, int d);
        return (32'h0F << 11) | (32'(o & 31) << 6) | (32'(b & 7) << 3) | 32'(d & 7);
    endfunction
    function automatic logic [31:0] enc_ma(int b, int d, int o);
        return (32'hF89 << 20) | (32'(b) << 16) | (32'(d) << 12) | 32'(o & 12'hFFF);
    endfunction
    function automatic logic [31:0] enc_mb(int b, int d, int p, int u, int w, int o);
        return (32'hF81 << 20) | (32'(b) << 16) | (32'(d) << 12) | (32'h1 << 11)
             | (32'(p) << 10) | (32'(u) << 9) | (32'(w) << 8) | 32'(o & 255);
    endfunction

    task automatic run(input logic [31:0] w, input bit mx, input bit cp,
                       input logic [7:0] bv, input int lat, input string req);
        int kind, bi, di, off;
        bit pre, add, wbk;
        logic [31:0] base, upd, acc;
        logic [3:0] fl_exp;
        model(w, mx, kind, bi, di, off, pre, add, wbk);
        base = rf[bi];
        upd  = add ? base + 32'(off) : base - 32'(off);
        acc  = pre ? upd : base;
        @(negedge clk);
        instr_word = w; mixed_set = mx; cond_pass = cp; instr_valid = 1'b1;
        chk(instr_ready == 1'b1, req, "ready before issue", 32'(instr_ready), 1);
        @(posedge clk);
        @(negedge clk);
        instr_valid = 1'b0;
        if (!cp) begin
            chk(retire && !mem_req && !dst_we && !wb_we, "R10", "nop retire/req/we",
                {28'h0, retire, mem_req, dst_we, wb_we}, 32'h8);
            chk({flag_literal, flag_preload, flag_unpriv, flag_undef} == 4'b0, "R10", "nop flags",
                32'({flag_literal, flag_preload, flag_unpriv, flag_undef}), 0);
        end else if (kind != 0) begin
            fl_exp = (kind == 1) ? 4'b1000 : (kind == 2) ? 4'b0100 : (kind == 3) ? 4'b0010 : 4'b0001;
            chk(retire && !mem_req && !dst_we && !wb_we, req, "diverted retire without request",
                {28'h0, retire, mem_req, dst_we, wb_we}, 32'h8);
            chk({flag_literal, flag_preload, flag_unpriv, flag_undef} == fl_exp, req, "flags",
                32'({flag_literal, flag_preload, flag_unpriv, flag_undef}), 32'(fl_exp));
        end else begin
            chk(mem_req == 1'b1 && retire == 1'b0, "R3", "request pulse", {30'h0, mem_req, retire}, 2);
            chk(mem_addr == acc, req, "access address", mem_addr, acc);
            instr_valid = 1'b1;
            instr_word  = w ^ 32'h0000_0001;
            for (int i = 0; i < lat; i++) begin
                @(posedge clk);
                @(negedge clk);
                chk(!mem_req && !retire && !instr_ready, "R12", "idle while waiting",
                    {29'h0, mem_req, retire, instr_ready}, 0);
            end
            instr_valid   = 1'b0;
            mem_rsp_valid = 1'b1;
            mem_rsp_byte  = bv;
            @(posedge clk);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(retire && dst_we && !mem_req, "R3", "retire with write", {29'h0, retire, dst_we, mem_req}, 6);
            chk(dst_idx == 4'(di), req, "dest index", 32'(dst_idx), 32'(di));
            chk(dst_data == {24'h0, bv}, "R3", "zero-extended byte", dst_data, {24'h0, bv});
            chk(wb_we == wbk, "R4", "writeback enable", 32'(wb_we), 32'(wbk));
            if (wbk) begin
                chk(wb_idx == 4'(bi), "R4", "writeback index", 32'(wb_idx), 32'(bi));
                chk(wb_data == upd, "R4", "writeback value", wb_data, upd);
            end
            chk({flag_literal, flag_preload, flag_unpriv, flag_undef} == 4'b0, req, "no flag on exec",
                32'({flag_literal, flag_preload, flag_unpriv, flag_undef}), 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R3 watchdog actual=hung expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0100;
        rf[4] = 32'h0000_0005;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(instr_ready && !mem_req && !retire && !dst_we && !wb_we, "R1", "reset outputs",
            {27'h0, instr_ready, mem_req, retire, dst_we, wb_we}, 32'h10);

        // R2 fixed set: offset add, pre-index subtract with wrap, post-index max offset
        run(enc_fx(14, 1, 1, 0, 3, 5, 12'h123), 0, 1, 8'hA5, 2, "R2");
        run(enc_fx(14, 1, 0, 1, 4, 6, 12'h010), 0, 1, 8'hFF, 0, "R2");
        run(enc_fx(0, 0, 1, 0, 7, 2, 12'hFFF), 0, 1, 8'h80, 3, "R4");
        run(enc_fx(1, 1, 1, 0, 9, 9, 12'h001), 0, 1, 8'h01, 1, "R2");
        // R8 hand-offs in fixed set
        run(enc_fx(14, 0, 1, 1, 3, 5, 4), 0, 1, 8'h00, 0, "R8");
        run(enc_fx(14, 1, 1, 0, 15, 5, 4), 0, 1, 8'h00, 0, "R8");
        // R9 unpredictable/undefined
        run(enc_fx(14, 1, 1, 0, 3, 15, 4), 0, 1, 8'h00, 0, "R9");
        run(enc_fx(14, 1, 1, 1, 6, 6, 4), 0, 1, 8'h00, 0, "R9");
        run(enc_fx(15, 1, 1, 0, 3, 5, 4), 0, 1, 8'h00, 0, "R9");
        run(32'h0000_0000, 0, 1, 8'h00, 0, "R9");
        // R10 condition failed
        run(enc_fx(14, 1, 1, 0, 3, 5, 4), 0, 0, 8'h00, 0, "R10");
        // R5 16-bit form
        run(enc_16(31, 5, 1), 1, 1, 8'h3C, 1, "R5");
        run(enc_16(0, 2, 7), 1, 1, 8'hC3, 0, "R5");
        run(32'h0000_7000, 1, 1, 8'h00, 0, "R9");
        // R6 first mixed 32-bit form
        run(enc_ma(2, 9, 12'hABC), 1, 1, 8'h5A, 2, "R6");
        run(enc_ma(2, 15, 1), 1, 1, 8'h00, 0, "R6");
        run(enc_ma(15, 9, 1), 1, 1, 8'h00, 0, "R8");
        // R7 second mixed 32-bit form
        run(enc_mb(8, 1, 1, 0, 0, 200), 1, 1, 8'h11, 1, "R7");
        run(enc_mb(8, 1, 0, 1, 1, 255), 1, 1, 8'h22, 2, "R7");
        run(enc_mb(4, 3, 1, 0, 1, 16), 1, 1, 8'h33, 0, "R7");
        run(enc_mb(8, 15, 1, 0, 0, 1), 1, 1, 8'h00, 0, "R7");
        run(enc_mb(8, 1, 1, 1, 0, 1), 1, 1, 8'h00, 0, "R7");
        run(enc_mb(8, 1, 0, 1, 0, 1), 1, 1, 8'h00, 0, "R7");
        run(enc_mb(15, 1, 1, 1, 1, 1), 1, 1, 8'h00, 0, "R8");
        run(enc_mb(8, 15, 1, 1, 1, 1), 1, 1, 8'h00, 0, "R9");
        run(enc_mb(8, 8, 0, 1, 1, 1), 1, 1, 8'h00, 0, "R9");
        run(enc_mb(8, 1, 1, 1, 1, 1) & ~32'h800, 1, 1, 8'h00, 0, "R9");
        run(32'hFFFF_FFFF, 1, 1, 8'h00, 0, "R9");
        // R11 one idle cycle after a diverted op shows the flags cleared
        @(negedge clk);
        chk({flag_literal, flag_preload, flag_unpriv, flag_undef, retire} == 5'b0, "R11", "flags pulse only",
            32'({flag_literal, flag_preload, flag_unpriv, flag_undef, retire}), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule